// File: doc/BRIEF.md
# Five-Channel Timer Tick Prescaler Tree

This block turns one peripheral clock into five independent tick-enable streams for a bank of timer channels. Two shared 8-bit prescalers each count off a programmable number of cycles. Channels 0 and 1 take their base tick from the first prescaler. Channels 2, 3 and 4 take theirs from the second. Each channel then divides its base tick by a power of two chosen by a 3-bit code. A per-channel source bit can replace the divided tick with an external tick input: external input 0 serves channels 0 and 1, and external input 1 serves channels 2 to 4. Each external input is synchronized and edge-detected before use.

Two configuration words are set through a plain register bus with address, write data, write enable and combinational read data. Every tick is a single-cycle enable in the peripheral clock domain. The block derives no clocks. Rewriting a configuration word restarts the counters that depend on it, so the first tick after a change already has the new period.

Top module: `tick_tree`

## Requirements
- R1: The prescaler word is at address 0x00, with prescaler 0 in bits 7:0 and prescaler 1 in bits 15:8. The channel word is at address 0x04, where channel c owns bits 4c+3:4c. Bits of the write data outside these fields are dropped and read as zero. Any other address reads zero.
- R2: Reading a configuration word returns the stored field values unchanged, including divider codes 5 to 7.
- R3: When a channel's source bit (bit 3 of its field) is 0, its tick period is (N+1)·2^code cycles. N is the prescaler of its group: prescaler 0 serves channels 0–1, prescaler 1 serves channels 2–4. The code is field bits 2:0.
- R4: Divider codes 5, 6 and 7 divide by 16, the same as code 4.
- R5: A prescaler value of 0 gives a base tick on every cycle. With divider code 0, the channel then ticks on every cycle.
- R6: When a channel's source bit is 1, the channel emits exactly one single-cycle tick for each rising edge of its group's external input. That tick appears at the third rising clock edge after the input changes. Falling edges and the other group's input produce nothing.
- R7: A write to the prescaler word restarts both prescalers and all five dividers. A write to the channel word restarts the dividers. The first tick after a prescaler-word write comes at the (N+1)·2^code-th clock edge after the write edge, and the period repeats after that.
- R8: Reset is synchronous and active-high. It clears both configuration words and all counters, and it holds every channel tick low while asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 8 | Register byte address |
| busWrData | input | 32 | Write data |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| extTickIn | input | 2 | Asynchronous external tick inputs, one per prescaler group |
| chanTick | output | 5 | Registered single-cycle tick enable per channel |

## Verification
The bound checker keeps its own copy of both configuration words and checks four things on every cycle: read data matches that copy, ticks stay low after a reset cycle, a zero prescaler with divider code 0 ticks on every cycle, and ticks never come back to back when a channel uses a divider above one or the external source. The exact periods, the grouping of channels onto prescalers, the restart latency after a write, the three-edge external latency and the handling of falling edges can only be shown by the bench's scenarios, which time each tick against the cycle of the write or input change.

// File: rtl/tick_tree_pkg.sv
package tick_tree_pkg;

  localparam int FIELD_W   = 4;  // per-channel field: [3]=source, [2:0]=code
  localparam int DIV_CNT_W = 4;  // enough to count to 16

  typedef struct packed {
    logic preLoad;  // prescaler word written: restart prescalers and dividers
    logic divLoad;  // channel word written: restart dividers
  } ctrlStrobes_t;

  // Terminal count of the per-channel divider (divisor minus one).
  function automatic logic [DIV_CNT_W-1:0] divLimit(input logic [2:0] code);
    case (code)
      3'd0:    divLimit = 4'd0;
      3'd1:    divLimit = 4'd1;
      3'd2:    divLimit = 4'd3;
      3'd3:    divLimit = 4'd7;
      default: divLimit = 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/tick_tree_ctrl.sv
module tick_tree_ctrl
  import tick_tree_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int PRE_W     = 8,
  parameter int NUM_PRE   = 2,
  parameter int NUM_CH    = 5,
  parameter int ADDR_PRE  = 0,
  parameter int ADDR_CHAN = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [DATA_W-1:0]           busWrData,
  input  logic                        busWrEn,
  output logic [DATA_W-1:0]           busRdData,
  output logic [PRE_W*NUM_PRE-1:0]    cfgPre,
  output logic [FIELD_W*NUM_CH-1:0]   cfgChan,
  output ctrlStrobes_t                strobes
);

  localparam int PRE_BITS  = PRE_W * NUM_PRE;
  localparam int CHAN_BITS = FIELD_W * NUM_CH;

  logic hitPre, hitChan;

  assign hitPre  = busWrEn && (busAddr == ADDR_W'(ADDR_PRE));
  assign hitChan = busWrEn && (busAddr == ADDR_W'(ADDR_CHAN));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgPre  <= '0;
      cfgChan <= '0;
    end else begin
      if (hitPre)  cfgPre  <= busWrData[PRE_BITS-1:0];
      if (hitChan) cfgChan <= busWrData[CHAN_BITS-1:0];
    end
  end

  always_comb begin
    strobes.preLoad = hitPre;
    strobes.divLoad = hitChan;
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(ADDR_PRE))
      busRdData = DATA_W'(cfgPre);
    else if (busAddr == ADDR_W'(ADDR_CHAN))
      busRdData = DATA_W'(cfgChan);
  end

endmodule

// File: rtl/tick_tree_dp.sv
module tick_tree_dp
  import tick_tree_pkg::*;
#(
  parameter int                PRE_W     = 8,
  parameter int                NUM_PRE   = 2,
  parameter int                NUM_CH    = 5,
  parameter logic [NUM_CH-1:0] GROUP_MAP = 5'b11100  // 1: channel uses prescaler 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctrlStrobes_t              strobes,
  input  logic [PRE_W*NUM_PRE-1:0]  cfgPre,
  input  logic [FIELD_W*NUM_CH-1:0] cfgChan,
  input  logic [NUM_PRE-1:0]        extTickIn,
  output logic [NUM_CH-1:0]         chanTick
);

  localparam int SYNC_STAGES = 3;  // two synchronizer flops plus edge history

  logic [NUM_PRE-1:0] preTick;
  logic [NUM_PRE-1:0] extEdge;
  logic [NUM_CH-1:0]  nextTick;

  for (genvar p = 0; p < NUM_PRE; p++) begin : g_pre
    logic [PRE_W-1:0]       preCnt;
    logic [PRE_W-1:0]       preVal;
    logic [SYNC_STAGES-1:0] syncPipe;

    assign preVal     = cfgPre[p*PRE_W +: PRE_W];
    assign preTick[p] = (preCnt == preVal);

    always_ff @(posedge clk) begin
      if (rst || strobes.preLoad)
        preCnt <= '0;
      else if (preCnt == preVal)
        preCnt <= '0;
      else
        preCnt <= preCnt + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) syncPipe <= '0;
      else     syncPipe <= {syncPipe[SYNC_STAGES-2:0], extTickIn[p]};
    end

    assign extEdge[p] = syncPipe[1] & ~syncPipe[2];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    localparam int GRP = GROUP_MAP[c] ? 1 : 0;

    logic [FIELD_W-1:0]   field;
    logic [DIV_CNT_W-1:0] divCnt;
    logic [DIV_CNT_W-1:0] limit;
    logic                 divTick;

    assign field   = cfgChan[c*FIELD_W +: FIELD_W];
    assign limit   = divLimit(field[2:0]);
    assign divTick = preTick[GRP] && (divCnt == limit);

    always_ff @(posedge clk) begin
      if (rst || strobes.preLoad || strobes.divLoad)
        divCnt <= '0;
      else if (preTick[GRP])
        divCnt <= (divCnt == limit) ? '0 : divCnt + 1'b1;
    end

    assign nextTick[c] = field[FIELD_W-1] ? extEdge[GRP] : divTick;
  end

  always_ff @(posedge clk) begin
    if (rst) chanTick <= '0;
    else     chanTick <= nextTick;
  end

endmodule

// File: rtl/tick_tree.sv
module tick_tree
  import tick_tree_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic [1:0]        extTickIn,
  output logic [4:0]        chanTick
);

  localparam int PRE_W   = 8;
  localparam int NUM_PRE = 2;
  localparam int NUM_CH  = 5;

  logic [PRE_W*NUM_PRE-1:0]  cfgPre;
  logic [FIELD_W*NUM_CH-1:0] cfgChan;
  ctrlStrobes_t              strobes;

  tick_tree_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W),
    .NUM_PRE(NUM_PRE), .NUM_CH(NUM_CH), .ADDR_PRE(0), .ADDR_CHAN(4)
  ) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdData(busRdData), .cfgPre(cfgPre),
    .cfgChan(cfgChan), .strobes(strobes)
  );

  tick_tree_dp #(
    .PRE_W(PRE_W), .NUM_PRE(NUM_PRE), .NUM_CH(NUM_CH), .GROUP_MAP(5'b11100)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .cfgPre(cfgPre),
    .cfgChan(cfgChan), .extTickIn(extTickIn), .chanTick(chanTick)
  );

endmodule

// File: rtl/tick_tree_chk.sv
module tick_tree_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busRdData,
  input logic [1:0]        extTickIn,
  input logic [4:0]        chanTick
);

  logic [15:0] shPre;
  logic [19:0] shChan;
  logic [2:0]  quiet;  // saturating cycles since last reset or write

  always_ff @(posedge clk) begin
    if (rst) begin
      shPre  <= '0;
      shChan <= '0;
      quiet  <= '0;
    end else begin
      if (busWrEn && busAddr == ADDR_W'(0)) shPre  <= busWrData[15:0];
      if (busWrEn && busAddr == ADDR_W'(4)) shChan <= busWrData[19:0];
      if (busWrEn)            quiet <= '0;
      else if (quiet != 3'd7) quiet <= quiet + 1'b1;
    end
  end

  assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (busAddr == ADDR_W'(0)) |-> (busRdData == DATA_W'(shPre)));

  assert_readback_chan_R1: assert property (@(posedge clk) disable iff (rst)
    (busAddr == ADDR_W'(4)) |-> (busRdData == DATA_W'(shChan)));

  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> (chanTick == 5'b0));

  assert_zero_prescale_R5: assert property (@(posedge clk) disable iff (rst)
    (quiet >= 3'd2 && shPre[7:0] == 8'd0 && shChan[3:0] == 4'd0) |-> chanTick[0]);

  assert_div_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (quiet >= 3'd2 && !shChan[7] && shChan[6:4] != 3'd0 && chanTick[1]) |=> !chanTick[1]);

  assert_ext_single_R6: assert property (@(posedge clk) disable iff (rst)
    (quiet >= 3'd2 && shChan[3] && chanTick[0]) |=> !chanTick[0]);

endmodule

bind tick_tree tick_tree_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tick_tree_tb.sv
module tick_tree_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busRdData;
  logic [1:0]  extTickIn = '0;
  logic [4:0]  chanTick;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tick_tree u_dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdData(busRdData), .extTickIn(extTickIn),
    .chanTick(chanTick)
  );

  // {pre0[63:56], pre1[55:48], chanWord[47:28], channel[27:24], period[23:0]}
  localparam int NVEC = 6;
  localparam logic [63:0] VEC [NVEC] = '{
    {8'd0,   8'd0, 20'h00000, 4'd0, 24'd1},
    {8'd2,   8'd7, 20'h00030, 4'd1, 24'd24},
    {8'd0,   8'd4, 20'h00100, 4'd2, 24'd10},
    {8'd5,   8'd1, 20'h04000, 4'd3, 24'd32},
    {8'd3,   8'd0, 20'h60000, 4'd4, 24'd16},
    {8'd255, 8'd9, 20'h00000, 4'd0, 24'd256}
  };
  localparam string VEC_REQ [NVEC] = '{"R5", "R3", "R3", "R3", "R4", "R3"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    busAddr = addr; busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] addr, output logic [31:0] data);
    busAddr = addr;
    #1 data = busRdData;
  endtask

  task automatic measure(input int ch, input int limit, output int lat, output int gap);
    lat = -1; gap = -1;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (chanTick[ch]) begin lat = k; break; end
    end
    if (lat >= 0)
      for (int k = 1; k <= limit; k++) begin
        @(negedge clk);
        if (chanTick[ch]) begin gap = k; break; end
      end
  endtask

  task automatic countTicks(input int cycles, output int c0, output int c2,
                            output int c4, output int firstC0);
    c0 = 0; c2 = 0; c4 = 0; firstC0 = -1;
    for (int k = 1; k <= cycles; k++) begin
      @(negedge clk);
      if (chanTick[0]) begin c0++; if (firstC0 < 0) firstC0 = k; end
      if (chanTick[2]) c2++;
      if (chanTick[4]) c4++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat, gap, c0, c2, c4, f0;

    // Reset state (R8)
    repeat (3) @(negedge clk);
    check(chanTick == 5'b0, "R8 ticks low in reset", chanTick, 0);
    rst = 1'b0;
    busRead(8'h00, rd); check(rd == 32'h0, "R8 prescaler word cleared", rd, 0);
    busRead(8'h04, rd); check(rd == 32'h0, "R8 channel word cleared", rd, 0);

    // Vector table: period and restart latency (R3, R4, R5, R7)
    for (int v = 0; v < NVEC; v++) begin
      int per, ch;
      per = int'(VEC[v][23:0]);
      ch  = int'(VEC[v][27:24]);
      busWrite(8'h04, {12'h0, VEC[v][47:28]});
      busWrite(8'h00, {16'h0, VEC[v][55:48], VEC[v][63:56]});
      measure(ch, 2 * per + 4, lat, gap);
      check(lat == per, {VEC_REQ[v], " R7 first tick after write"}, lat, per);
      check(gap == per, {VEC_REQ[v], " period"}, gap, per);
    end

    // Register layout and readback (R1, R2)
    busWrite(8'h04, 32'hFFFF_FFFF);
    busRead(8'h04, rd); check(rd == 32'h000F_FFFF, "R1 unused bits of channel word read zero", rd, 32'h000F_FFFF);
    busWrite(8'h04, 32'h0005_D6E7);
    busRead(8'h04, rd); check(rd == 32'h0005_D6E7, "R2 channel word readback", rd, 32'h0005_D6E7);
    busWrite(8'h00, 32'hABCD_1234);
    busRead(8'h00, rd); check(rd == 32'h0000_1234, "R1 prescaler word fields", rd, 32'h0000_1234);
    busRead(8'h08, rd); check(rd == 32'h0, "R1 unmapped address reads zero", rd, 0);

    // Restart mid-period (R7)
    busWrite(8'h04, 32'h0);
    busWrite(8'h00, 32'h0000_0009);
    repeat (5) @(negedge clk);
    busWrite(8'h00, 32'h0000_0009);
    measure(0, 30, lat, gap);
    check(lat == 10, "R7 rewrite restarts prescaler", lat, 10);

    // External tick source (R6): ch0, ch2, ch4 select external
    busWrite(8'h04, 32'h0008_0808);
    busWrite(8'h00, 32'h0);
    countTicks(8, c0, c2, c4, f0);
    check(c0 + c2 + c4 == 0, "R6 no ticks without external edges", c0 + c2 + c4, 0);
    extTickIn[0] = 1'b1;
    countTicks(10, c0, c2, c4, f0);
    check(c0 == 1, "R6 one tick per rising edge on ch0", c0, 1);
    check(f0 == 3, "R6 external latency", f0, 3);
    check(c2 == 0, "R6 other group unaffected", c2, 0);
    extTickIn[1] = 1'b1;
    countTicks(10, c0, c2, c4, f0);
    check(c2 == 1 && c4 == 1, "R6 ext1 ticks ch2 and ch4", c2 * 10 + c4, 11);
    check(c0 == 0, "R6 held-high input gives no more ticks", c0, 0);
    extTickIn = 2'b00;
    countTicks(10, c0, c2, c4, f0);
    check(c0 + c2 + c4 == 0, "R6 falling edges ignored", c0 + c2 + c4, 0);

    // Reset clears configuration and ticks (R8)
    busWrite(8'h00, 32'h0000_0303);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(chanTick == 5'b0, "R8 ticks low during reset", chanTick, 0);
    busRead(8'h00, rd); check(rd == 32'h0, "R8 reset clears prescaler word", rd, 0);
    busRead(8'h04, rd); check(rd == 32'h0, "R8 reset clears channel word", rd, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule